// File: doc/BRIEF.md
# Bus Master Data Parity Responder

This block watches the data phases of a 32-bit PCI-style bus while the device is the bus master. On reads it checks the parity of the data that the target returns. On writes it listens for the target's parity error report. Any data parity error updates two sticky status bits and sets a system-interrupt flag. When parity response is enabled, a read error also makes the block drive the shared, sustained tri-state PERR# line low. After the last low cycle it drives the line high for one cycle and then releases it.

A read data phase completes on a clock edge where the device is master in the read direction and both IRDY# and TRDY# are sampled low. At that edge the block captures AD and C/BE#. It compares them with PAR on the next edge, because the target supplies PAR one clock after TRDY#. The block has no data path, so an error never stops or changes the transfer. The host clears each sticky bit by writing one to it, which reaches the block as a one-cycle clear strobe.

Top module: `mpg_top`

## Requirements
- R1: While reset is asserted and after it is released, the block shows both status bits and the interrupt flag at zero, int_n high and perr_oe low.
- R2: A read data phase completes on a clock edge with master_act=1, dir_read=1, irdy_n=0 and trdy_n=0. The AD and C/BE# values of that edge and the PAR value of the following edge form a 37-bit even-parity word. An odd count of ones in that word is a read parity error, and it is flagged at the edge that samples PAR.
- R3: Bus values on edges where trdy_n, irdy_n or master_act does not complete a read data phase are never parity checked.
- R4: Every data parity error sets stat_dpe, whatever perr_rsp_en holds.
- R5: If perr_rsp_en=1, a read parity error also sets stat_dpr. It drives perr_n_out=0 with perr_oe=1 during the cycle after the PAR edge, so the line is seen low on the second edge after the data.
- R6: Read parity errors on consecutive PAR edges keep PERR# low without a gap. After the last low cycle the block drives PERR# high with perr_oe=1 for exactly one cycle, and then perr_oe returns to 0.
- R7: On any edge with master_act=1, dir_read=0 and perr_n_in=0, the block records a write parity error. It sets stat_dpe, and also stat_dpr if perr_rsp_en=1. Write errors never drive PERR#.
- R8: Any data parity error sets sys_int_flag, whatever perr_rsp_en holds. int_n is 0 exactly while sys_int_flag=1 and sys_int_en=1.
- R9: stat_dpe, stat_dpr and sys_int_flag are sticky. Each is cleared only by reset or by its own clear strobe. A new error on the same edge as the clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 32 | Address/data lines |
| bus_cbe_n | input | 4 | Command/byte-enable lines |
| bus_par | input | 1 | Parity line |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| perr_n_in | input | 1 | Sampled PERR# line, active low |
| master_act | input | 1 | Device is the current bus master |
| dir_read | input | 1 | 1 = read transfer, 0 = write transfer |
| perr_rsp_en | input | 1 | Parity response enable |
| sys_int_en | input | 1 | System interrupt enable |
| clr_dpe | input | 1 | Write-one clear of stat_dpe |
| clr_dpr | input | 1 | Write-one clear of stat_dpr |
| clr_sint | input | 1 | Write-one clear of sys_int_flag |
| stat_dpe | output | 1 | Detected parity error status bit |
| stat_dpr | output | 1 | Data parity reported status bit |
| sys_int_flag | output | 1 | System interrupt flag |
| int_n | output | 1 | Interrupt request, active low |
| perr_n_out | output | 1 | PERR# drive value |
| perr_oe | output | 1 | PERR# output enable |

## Verification
The hardest case to reach is a run of read data phases that complete back to back, where the PAR of one phase shares its edge with the AD of the next and errors arrive on adjacent edges. Only that pattern shows whether PERR# stays low without a gap and releases once. The stimulus reaches it on purpose by holding TRDY# and IRDY# low for several edges. Each cycle it computes PAR from the previous edge's data, inverted on chosen phases. A long random phase then mixes partial handshakes, role changes, clears that collide with new errors, and enable toggles.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int unsigned MPG_AD_W = 32;
  localparam int unsigned MPG_BE_W = 4;

  // sticky status slots
  typedef enum logic [1:0] {
    SLOT_DPE  = 2'd0,
    SLOT_DPR  = 2'd1,
    SLOT_SINT = 2'd2
  } sticky_slot_e;

  localparam int unsigned MPG_NSLOT = 3;

  // parity of a word: 1 means an odd count of ones
  function automatic logic odd_ones(input logic [MPG_AD_W+MPG_BE_W-1:0] w);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < MPG_AD_W + MPG_BE_W; i++) acc = acc ^ w[i];
    return acc;
  endfunction
endpackage

// File: rtl/mpg_rd_check.sv
module mpg_rd_check
  import mpg_pkg::*;
#(
  parameter int unsigned AD_W = MPG_AD_W,
  parameter int unsigned BE_W = MPG_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par,
  input  logic            take,
  output logic            rd_err
);
  localparam int unsigned WORD_W = AD_W + BE_W;

  logic held_odd;
  logic held_vld;
  logic [WORD_W-1:0] word_now;

  always_comb begin
    word_now = '0;
    word_now[WORD_W-1:0] = {ad, cbe_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_odd <= 1'b0;
      held_vld <= 1'b0;
    end else begin
      held_vld <= take;
      held_odd <= take ? odd_ones(word_now) : 1'b0;
    end
  end

  // PAR arrives one clock after the captured data
  assign rd_err = held_vld & (held_odd ^ par);
endmodule

// File: rtl/mpg_perr_drv.sv
module mpg_perr_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_req,
  output logic perr_n_out,
  output logic perr_oe
);
  logic low_q;
  logic rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      low_q <= drive_req;
      rel_q <= low_q & ~drive_req;
    end
  end

  assign perr_n_out = ~low_q;
  assign perr_oe    = low_q | rel_q;
endmodule

// File: rtl/mpg_sticky.sv
module mpg_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/mpg_top.sv
module mpg_top
  import mpg_pkg::*;
#(
  parameter int unsigned AD_W = MPG_AD_W,
  parameter int unsigned BE_W = MPG_BE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] bus_ad,
  input  logic [BE_W-1:0] bus_cbe_n,
  input  logic            bus_par,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            perr_n_in,
  input  logic            master_act,
  input  logic            dir_read,
  input  logic            perr_rsp_en,
  input  logic            sys_int_en,
  input  logic            clr_dpe,
  input  logic            clr_dpr,
  input  logic            clr_sint,
  output logic            stat_dpe,
  output logic            stat_dpr,
  output logic            sys_int_flag,
  output logic            int_n,
  output logic            perr_n_out,
  output logic            perr_oe
);
  // named internal events
  logic rd_take;
  logic rd_err;
  logic wr_err;
  logic any_err;
  logic perr_req;
  logic [MPG_NSLOT-1:0] st_set;
  logic [MPG_NSLOT-1:0] st_clr;
  logic [MPG_NSLOT-1:0] st_q;

  assign rd_take  = master_act & dir_read & ~irdy_n & ~trdy_n;
  assign wr_err   = master_act & ~dir_read & ~perr_n_in;
  assign any_err  = rd_err | wr_err;
  assign perr_req = rd_err & perr_rsp_en;

  mpg_rd_check #(.AD_W(AD_W), .BE_W(BE_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .ad     (bus_ad),
    .cbe_n  (bus_cbe_n),
    .par    (bus_par),
    .take   (rd_take),
    .rd_err (rd_err)
  );

  mpg_perr_drv u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_req  (perr_req),
    .perr_n_out (perr_n_out),
    .perr_oe    (perr_oe)
  );

  always_comb begin
    st_set = '0;
    st_clr = '0;
    st_set[SLOT_DPE]  = any_err;
    st_set[SLOT_DPR]  = any_err & perr_rsp_en;
    st_set[SLOT_SINT] = any_err;
    st_clr[SLOT_DPE]  = clr_dpe;
    st_clr[SLOT_DPR]  = clr_dpr;
    st_clr[SLOT_SINT] = clr_sint;
  end

  for (genvar g = 0; g < MPG_NSLOT; g++) begin : g_st
    mpg_sticky u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (st_set[g]),
      .clr   (st_clr[g]),
      .q     (st_q[g])
    );
  end

  assign stat_dpe     = st_q[SLOT_DPE];
  assign stat_dpr     = st_q[SLOT_DPR];
  assign sys_int_flag = st_q[SLOT_SINT];
  assign int_n        = ~(sys_int_flag & sys_int_en);
endmodule

// File: rtl/mpg_chk.sv
module mpg_chk (
  input logic clk,
  input logic rst_n,
  input logic trdy_n,
  input logic irdy_n,
  input logic master_act,
  input logic dir_read,
  input logic clr_dpe,
  input logic rd_err,
  input logic stat_dpe,
  input logic stat_dpr,
  input logic sys_int_flag,
  input logic perr_n_out,
  input logic perr_oe
);
  AST_CHECK_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(master_act && dir_read && !trdy_n && !irdy_n)); // R3
  AST_DPR_WITH_DPE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_dpr) |-> stat_dpe); // R4
  AST_LOW_MEANS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_n_out) |-> stat_dpr); // R5
  AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out) |=> !(perr_oe && perr_n_out)); // R6
  AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_n_out) |-> $past(perr_oe && !perr_n_out)); // R6
  AST_SINT_WITH_DPE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_dpe) |-> sys_int_flag); // R8
  AST_DPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_dpe && !clr_dpe) |=> stat_dpe); // R9
endmodule

bind mpg_top mpg_chk u_mpg_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trdy_n       (trdy_n),
  .irdy_n       (irdy_n),
  .master_act   (master_act),
  .dir_read     (dir_read),
  .clr_dpe      (clr_dpe),
  .rd_err       (rd_err),
  .stat_dpe     (stat_dpe),
  .stat_dpr     (stat_dpr),
  .sys_int_flag (sys_int_flag),
  .perr_n_out   (perr_n_out),
  .perr_oe      (perr_oe)
);

// File: tb/test_mpg_top.sv
module test_mpg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_ad = '0;
  logic [3:0]  bus_cbe_n = '0;
  logic bus_par = 1'b0, irdy_n = 1'b1, trdy_n = 1'b1, perr_n_in = 1'b1;
  logic master_act = 1'b0, dir_read = 1'b0, perr_rsp_en = 1'b0, sys_int_en = 1'b0;
  logic clr_dpe = 1'b0, clr_dpr = 1'b0, clr_sint = 1'b0;
  logic stat_dpe, stat_dpr, sys_int_flag, int_n, perr_n_out, perr_oe;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  mpg_top i_mpg_top (.*);

  // behavioural reference model
  bit m_wait, m_wodd, m_low, m_rel, m_dpe, m_dpr, m_sint;
  int m_lowrun; // lowered cycles in a row

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_wodd = 0; m_low = 0; m_rel = 0;
      m_dpe = 0; m_dpr = 0; m_sint = 0; m_lowrun = 0;
    end else begin
      bit ones_odd, rerr, werr, err;
      int cnt;
      rerr = m_wait && (m_wodd != bus_par);
      werr = master_act && !dir_read && !perr_n_in;
      err  = rerr || werr;
      m_rel = m_low && !(rerr && perr_rsp_en);
      m_low = rerr && perr_rsp_en;
      m_lowrun = m_low ? m_lowrun + 1 : 0;
      m_dpe  = err ? 1 : (clr_dpe ? 0 : m_dpe);
      m_dpr  = (err && perr_rsp_en) ? 1 : (clr_dpr ? 0 : m_dpr);
      m_sint = err ? 1 : (clr_sint ? 0 : m_sint);
      cnt = $countones({bus_ad, bus_cbe_n});
      ones_odd = (cnt % 2) == 1;
      m_wait = master_act && dir_read && !irdy_n && !trdy_n;
      m_wodd = ones_odd;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R4 stat_dpe", stat_dpe, m_dpe);
    chk("R5 stat_dpr", stat_dpr, m_dpr);
    chk("R8 sys_int_flag", sys_int_flag, m_sint);
    chk("R8 int_n", int_n, !(m_sint && sys_int_en));
    chk("R6 perr_oe", perr_oe, m_low || m_rel);
    if (perr_oe) chk("R5 perr_n_out", perr_n_out, !m_low);
  endtask

  // drive one cycle: called right after a negedge
  task automatic step(input bit act, input bit rd, input bit ir, input bit tr,
                      input logic [31:0] ad, input logic [3:0] be, input bit pr,
                      input bit pin);
    master_act = act; dir_read = rd; irdy_n = ir; trdy_n = tr;
    bus_ad = ad; bus_cbe_n = be; bus_par = pr; perr_n_in = pin;
    @(negedge clk);
    compare_all();
  endtask

  function automatic bit odd37(input logic [31:0] a, input logic [3:0] b);
    return ($countones({a, b}) % 2) == 1;
  endfunction

  initial begin
    bit pend_odd;
    bit [7:0] sel;
    logic [31:0] a;
    logic [3:0] b;
    @(negedge clk);
    // R1 reset state
    chk("R1 dpe rst", stat_dpe, 0);
    chk("R1 oe rst", perr_oe, 0);
    chk("R1 int_n rst", int_n, 1);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    chk("R1 sint after rst", sys_int_flag, 0);

    // R2 good read: no error
    perr_rsp_en = 1; sys_int_en = 1;
    a = 32'h1234_5678; b = 4'h0;
    step(1, 1, 0, 0, a, b, 0, 1);
    step(1, 1, 1, 1, 32'h0, 4'h0, odd37(a, b), 1);
    chk("R2 good parity", stat_dpe, 0);

    // R3 bad parity data without TRDY
    step(1, 1, 0, 1, 32'h0000_0001, 4'h0, 0, 1);
    step(1, 1, 1, 1, 32'h0, 4'h0, 0, 1);
    chk("R3 unchecked before trdy", stat_dpe, 0);

    // R5 bad read, latency: low seen on second edge after data
    a = 32'h0000_0003; b = 4'h1;
    step(1, 1, 0, 0, a, b, 0, 1);
    chk("R5 no drive at data", perr_oe, 0);
    step(1, 1, 1, 1, 32'h0, 4'h0, !odd37(a, b), 1);
    chk("R5 drive low", perr_n_out, 0);
    chk("R5 oe on", perr_oe, 1);
    step(0, 0, 1, 1, 32'h0, 4'h0, 0, 1);
    chk("R6 release high", perr_n_out, 1);
    chk("R6 release oe", perr_oe, 1);
    step(0, 0, 1, 1, 32'h0, 4'h0, 0, 1);
    chk("R6 released", perr_oe, 0);

    // R6 back-to-back erroring read phases
    pend_odd = 0;
    for (int k = 0; k < 4; k++) begin
      a = 32'hA5A5_0000 + k; b = 4'(k);
      step(1, 1, 0, 0, a, b, (k == 0) ? 0 : !pend_odd, 1);
      pend_odd = odd37(a, b);
    end
    step(1, 1, 1, 1, 32'h0, 4'h0, !pend_odd, 1);
    chk("R6 still low", perr_n_out, 0);
    step(0, 0, 1, 1, 32'h0, 4'h0, 0, 1);
    step(0, 0, 1, 1, 32'h0, 4'h0, 0, 1);
    chk("R6 single release", perr_oe, 0);

    // R9 clear, R4/R8 without enable, R7 write error
    clr_dpe = 1; clr_dpr = 1; clr_sint = 1;
    step(0, 0, 1, 1, 32'h0, 4'h0, 0, 1);
    clr_dpe = 0; clr_dpr = 0; clr_sint = 0;
    chk("R9 cleared", stat_dpe, 0);
    perr_rsp_en = 0;
    step(1, 0, 0, 0, 32'h0, 4'h0, 0, 0);
    chk("R7 write sets dpe", stat_dpe, 1);
    chk("R7 no dpr w/o en", stat_dpr, 0);
    chk("R8 sint w/o en", sys_int_flag, 1);
    chk("R7 no drive on write", perr_oe, 0);
    // R9 clear colliding with error: error wins
    clr_dpe = 1;
    step(1, 0, 0, 0, 32'h0, 4'h0, 0, 0);
    clr_dpe = 0;
    chk("R9 set beats clear", stat_dpe, 1);

    // random mix
    pend_odd = 0;
    for (int k = 0; k < 4000; k++) begin
      sel = 8'($urandom);
      perr_rsp_en = (sel[7:5] != 0);
      sys_int_en  = sel[4] | sel[3];
      clr_dpe  = ($urandom % 8) == 0;
      clr_dpr  = ($urandom % 8) == 0;
      clr_sint = ($urandom % 8) == 0;
      a = $urandom; b = 4'($urandom);
      step(($urandom % 5) != 0, ($urandom % 3) != 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0, a, b, pend_odd ^ (($urandom % 5) == 0),
           ($urandom % 6) != 0);
      pend_odd = odd37(a, b);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule